// File: doc/BRIEF.md
# Fully Associative Translation Cache with True LRU Replacement

This block keeps the most recent virtual-to-physical page mappings for 4 KB pages. A lookup presents a full virtual address. The upper 20 bits, the virtual page number, are compared against all 32 stored tags in parallel. In the same cycle the block reports either a hit, with the physical address built from the stored frame number and the untouched 12-bit page offset, or a miss. A hit needs no page-table access.

On a miss, the block asks an external table walker for the mapping. It latches the missing page number and holds one walk outstanding. The walker answers with one of two outcomes. A frame number is installed over the chosen victim: the lowest-numbered empty slot if one exists, otherwise the least recently used slot. A fault installs nothing. A flush input empties the whole cache in one cycle.

The walk control is a two-state machine. `WK_IDLE` moves to `WK_BUSY` on the transition *miss-launch*, which is a missing lookup while idle; that cycle pulses `walk_req`. `WK_BUSY` returns to `WK_IDLE` on the transition *answer*, which is any walker response. A response that carries no fault and arrives without a flush performs the fill. Every hit and every fill makes the touched entry the most recently used. If a hit and a fill fall in the same cycle, only the fill updates recency.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid. Every lookup misses and `walk_busy` is low.
- R2: A lookup of an installed page raises `lk_hit` in the same cycle. `lk_paddr[31:12]` then equals the installed frame number.
- R3: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]` for any offset.
- R4: A missing lookup raises `lk_miss` in the same cycle. When idle, it also pulses `walk_req` and latches the page number on `walk_vpn` from the next cycle. While a walk is outstanding, a miss raises no `walk_req`.
- R5: A response with `resp_fault`=0 installs the pair (`walk_vpn`, `resp_pfn`). It is visible to lookups from the next cycle, and `walk_busy` falls.
- R6: A response with `resp_fault`=1 installs nothing, and `walk_busy` falls.
- R7: Empty slots are used before any valid entry is evicted, so 32 distinct fills into an empty cache all remain present.
- R8: A fill into a full cache evicts the entry whose last hit or fill is oldest.
- R9: `flush` invalidates every entry at the next edge. A response arriving in the same cycle as `flush` is discarded, but it still ends the walk.
- R10: `lk_hit` and `lk_miss` are never both high, and both are low while `lk_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid mapping |
| lk_miss | output | 1 | Lookup found no mapping |
| lk_paddr | output | 32 | Frame number and passed-through offset |
| walk_req | output | 1 | One-cycle request for a table walk |
| walk_busy | output | 1 | A walk is outstanding |
| walk_vpn | output | 20 | Page number being walked |
| resp_valid | input | 1 | Walker response strobe |
| resp_fault | input | 1 | Walk ended in a page fault |
| resp_pfn | input | 20 | Frame number found by the walker |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions assume that the walker responds only while `walk_busy` is high. They also assume that `resp_fault` and `resp_pfn` are meaningful only with `resp_valid`. The stimulus keeps to this by answering every `walk_req` exactly once before the next one. It never issues a hit lookup in the same cycle as a fill, so the recency order it predicts matches the one the block keeps.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_BUSY = 1'b1
    } walk_state_t;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [PFN_W-1:0]   hit_pfn,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [VPN_W-1:0] tag_q [ENTRIES];
    logic [PFN_W-1:0] pfn_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
        end else if (flush) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_vpn;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (tag_q[g] == look_vpn);
    end

    assign hit_any = |match_vec;

    // at most one slot matches, so an OR-reduction selects it
    always_comb begin
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
                hit_pfn = hit_pfn | pfn_q[i];
            end
        end
    end
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    // rank 0 = most recent, ENTRIES-1 = least recent; ranks form a permutation
    logic [IDX_W-1:0] rank_q [ENTRIES];
    logic [IDX_W-1:0] touched_rank;

    assign touched_rank = rank_q[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                rank_q[i] <= IDX_W'(i);
            end
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    rank_q[i] <= '0;
                end else if (rank_q[i] < touched_rank) begin
                    rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
        end
    end

    // lowest empty slot wins; otherwise the oldest-ranked slot
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rank_q[i] == IDX_W'(ENTRIES - 1)) begin
                victim_idx = IDX_W'(i);
            end
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                victim_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xc_walk_fsm.sv
module xc_walk_fsm
    import xc_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_miss,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             resp_valid,
    input  logic             resp_fault,
    input  logic             flush,
    output walk_state_t      state,
    output logic             walk_req,
    output logic             walk_busy,
    output logic [VPN_W-1:0] walk_vpn,
    output logic             fill_en
);
    walk_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_vpn <= '0;
        end else if (walk_req) begin
            walk_vpn <= miss_vpn;
        end
    end

    // transitions: miss-launch and answer
    always_comb begin
        state_d = state;
        unique case (state)
            WK_IDLE: if (lk_miss)    state_d = WK_BUSY;
            WK_BUSY: if (resp_valid) state_d = WK_IDLE;
            default: state_d = WK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        walk_req  = 1'b0;
        walk_busy = 1'b0;
        fill_en   = 1'b0;
        unique case (state)
            WK_IDLE: walk_req = lk_miss;
            WK_BUSY: begin
                walk_busy = 1'b1;
                fill_en   = resp_valid && !resp_fault && !flush;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PFN_W+OFF_W-1:0] lk_paddr,
    output logic                   walk_req,
    output logic                   walk_busy,
    output logic [VPN_W-1:0]       walk_vpn,
    input  logic                   resp_valid,
    input  logic                   resp_fault,
    input  logic [PFN_W-1:0]       resp_pfn,
    input  logic                   flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]   look_vpn;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [PFN_W-1:0]   hit_pfn;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_en;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;
    walk_state_t        state;

    assign look_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];
    assign lk_hit   = lk_valid && hit_any;
    assign lk_miss  = lk_valid && !hit_any;
    assign lk_paddr = {hit_pfn, lk_vaddr[OFF_W-1:0]};

    // a fill takes precedence over a hit for the recency update
    assign touch_en  = fill_en || lk_hit;
    assign touch_idx = fill_en ? victim_idx : hit_idx;

    xc_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (fill_en),
        .wr_idx    (victim_idx),
        .wr_vpn    (walk_vpn),
        .wr_pfn    (resp_pfn),
        .look_vpn  (look_vpn),
        .match_vec (match_vec),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .hit_pfn   (hit_pfn),
        .valid_vec (valid_vec)
    );

    xc_lru #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    xc_walk_fsm #(
        .VPN_W(VPN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_miss    (lk_miss),
        .miss_vpn   (look_vpn),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .flush      (flush),
        .state      (state),
        .walk_req   (walk_req),
        .walk_busy  (walk_busy),
        .walk_vpn   (walk_vpn),
        .fill_en    (fill_en)
    );
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic [PFN_W+OFF_W-1:0] lk_paddr,
    input logic                   walk_req,
    input logic                   walk_busy,
    input logic                   resp_valid,
    input logic                   resp_fault,
    input logic                   flush,
    input logic [ENTRIES-1:0]     match_vec,
    input logic [ENTRIES-1:0]     valid_vec
);
    a_r10_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    a_r10_quiet_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    a_r4_req_only_idle_miss: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (lk_miss && !walk_busy));

    a_r4_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |=> walk_busy);

    a_r6_fault_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && resp_valid && resp_fault && !flush) |=> (valid_vec == $past(valid_vec)));

    a_r5_fill_adds_or_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && resp_valid && !resp_fault && !flush) |=>
        ((&$past(valid_vec)) || ($countones(valid_vec) == $countones($past(valid_vec)) + 1)));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    a_r5_answer_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && resp_valid) |=> !walk_busy);
endmodule

bind xlate_cache xc_checker #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_paddr   (lk_paddr),
    .walk_req   (walk_req),
    .walk_busy  (walk_busy),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .flush      (flush),
    .match_vec  (match_vec),
    .valid_vec  (valid_vec)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, walk_req, walk_busy;
    logic [31:0] lk_paddr;
    logic [19:0] walk_vpn;
    logic        resp_valid = 1'b0;
    logic        resp_fault = 1'b0;
    logic [19:0] resp_pfn = '0;
    logic        flush = 1'b0;

    always #5 clk = ~clk;

    xlate_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .walk_req(walk_req), .walk_busy(walk_busy), .walk_vpn(walk_vpn),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pfn(resp_pfn),
        .flush(flush)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference model: page numbers ordered most recent first
    logic [19:0] mru_q[$];
    logic [19:0] pfn_of [logic [19:0]];
    bit          busy_m = 0;
    logic [19:0] pend_vpn = '0;

    // scoreboard queue: {hit, paddr}
    logic [32:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int find_vpn(input logic [19:0] v);
        for (int i = 0; i < mru_q.size(); i++) if (mru_q[i] == v) return i;
        return -1;
    endfunction

    // driver: apply one lookup, push the predicted result
    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input string tag);
        int pos;
        bit exp_req;
        @(posedge clk); #1;
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        pos = find_vpn(vpn);
        if (pos >= 0) begin
            exp_q.push_back({1'b1, pfn_of[vpn], off});
            mru_q.delete(pos);
            mru_q.push_front(vpn);
            exp_req = 0;
        end else begin
            exp_q.push_back({1'b0, 32'h0});
            exp_req = !busy_m;
        end
        tag_q.push_back(tag);
        #2;
        chk(walk_req == exp_req, {tag, " walk_req"}, walk_req, exp_req);
        if (exp_req) begin
            busy_m = 1;
            pend_vpn = vpn;
        end
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic respond(input logic [19:0] pfn, input bit fault, input bit fl, input string tag);
        chk(walk_vpn == pend_vpn, {tag, " walk_vpn"}, walk_vpn, pend_vpn);
        @(posedge clk); #1;
        resp_valid = 1'b1;
        resp_fault = fault;
        resp_pfn   = pfn;
        flush      = fl;
        if (fl) begin
            mru_q.delete();
        end else if (!fault) begin
            if (mru_q.size() == 32) void'(mru_q.pop_back());
            mru_q.push_front(pend_vpn);
            pfn_of[pend_vpn] = pfn;
        end
        busy_m = 0;
        @(posedge clk); #1;
        resp_valid = 1'b0;
        resp_fault = 1'b0;
        flush      = 1'b0;
        chk(walk_busy == 1'b0, {tag, " busy after answer"}, walk_busy, 0);
    endtask

    task automatic do_flush();
        @(posedge clk); #1;
        flush = 1'b1;
        mru_q.delete();
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    task automatic miss_fill(input logic [19:0] vpn, input logic [19:0] pfn, input string tag);
        look(vpn, 12'h000, tag);
        respond(pfn, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare design outputs against the scoreboard
    always @(negedge clk) begin
        if (lk_valid && exp_q.size() > 0) begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(lk_hit == e[32], {t, " hit"}, lk_hit, e[32]);
            chk(lk_miss == !e[32], {t, " miss"}, lk_miss, !e[32]);
            if (e[32]) chk(lk_paddr == e[31:0], {t, " paddr"}, lk_paddr, e[31:0]);
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(walk_busy == 1'b0, "R1 busy", walk_busy, 0);
        chk(lk_hit == 1'b0, "R1 hit", lk_hit, 0);
        look(20'h12345, 12'h000, "R1");
        // R6: fault installs nothing
        respond(20'h0BEEF, 1'b1, 1'b0, "R6");
        look(20'h12345, 12'h000, "R6");
        respond(20'hABCDE, 1'b0, 1'b0, "R5");
        // R2 / R3: hits at several offsets
        look(20'h12345, 12'h000, "R2");
        look(20'h12345, 12'hFFF, "R3");
        look(20'h12345, 12'h5A5, "R3");
        // R4: second miss while busy raises no request
        look(20'h00111, 12'h010, "R4");
        look(20'h00222, 12'h020, "R4");
        respond(20'h33333, 1'b0, 1'b0, "R4");
        look(20'h00111, 12'h7FE, "R5");
        look(20'h00222, 12'h000, "R4");
        respond(20'h0, 1'b1, 1'b0, "R6");
        // R7: 32 fills into an empty cache all stay present
        do_flush();
        for (int i = 0; i < 32; i++)
            miss_fill(20'h40000 + 20'(i), 20'h80000 + 20'(i * 3), "R7");
        for (int i = 0; i < 32; i++)
            look(20'h40000 + 20'(i), 12'(i * 7), "R7");
        // R8: recency decides the victim
        look(20'h40000, 12'h001, "R8");
        look(20'h40001, 12'h002, "R8");
        miss_fill(20'h50000, 20'h50505, "R8");
        look(20'h40002, 12'h000, "R8");
        respond(20'h0, 1'b1, 1'b0, "R8");
        look(20'h40000, 12'h003, "R8");
        look(20'h50000, 12'h004, "R8");
        miss_fill(20'h50001, 20'h51515, "R8");
        look(20'h40003, 12'h000, "R8");
        respond(20'h0, 1'b1, 1'b0, "R8");
        look(20'h40004, 12'h005, "R8");
        // R9: flush together with a response
        look(20'h60000, 12'h000, "R9");
        respond(20'h66666, 1'b0, 1'b1, "R9");
        look(20'h50000, 12'h000, "R9");
        respond(20'h0, 1'b1, 1'b0, "R9");
        look(20'h60000, 12'h000, "R9");
        respond(20'h0, 1'b1, 1'b0, "R9");
        // R10: no lookup, no hit and no miss
        miss_fill(20'h70000, 20'h77777, "R10");
        @(posedge clk); #1;
        lk_vaddr = {20'h70000, 12'h123};
        #3;
        chk(lk_hit == 1'b0, "R10 hit idle", lk_hit, 0);
        chk(lk_miss == 1'b0, "R10 miss idle", lk_miss, 0);
        look(20'h70000, 12'h123, "R10");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule